// File: doc/BRIEF.md
# Digitizer Zero Suppression Filter

This block sits on one channel of a digitizer, between the stream of 14-bit converted samples and the event store. It decides what is kept. The input stream is grouped into events by start and end markers. Each cycle the block looks at one sample, the mode code and a small set of threshold and count settings. It then does one of four things:

- Forward every sample unchanged (pass-through).
- Keep or drop a whole event by comparing the event's summed amplitude with a threshold (integral suppression).
- Keep or drop a whole event depending on whether a long enough run of consecutive samples lies beyond a threshold (amplitude suppression).
- Keep only the samples near the places where the signal is beyond the threshold, and replace every dropped stretch with one skip marker that carries its length (zero length encoding).

In the two whole-event modes the samples are held in a circular buffer until the end marker. A kept event is then replayed one sample per cycle, queued behind any earlier kept event that has not finished. A dropped event is rewound out of the buffer and produces no sample output. For every event, a done pulse reports whether the event was kept.

The settings are held stable during an event. The mode changes only while the block is idle, meaning no replay is pending and the look-back line is empty. Whole-event mode events hold at most `DEPTH` samples.

Top module: `zs_filter`

## Requirements
- R1: While reset is asserted and after it is released with no input, `out_valid`, `out_last`, `out_skip` and `out_evt_done` are all 0.
- R2: Mode code 0000 (pass-through), and every code above 0011, presents each valid input sample on `out_data` one cycle later, with `out_valid` = 1 and `out_last` equal to that sample's end marker.
- R3: In mode code 0001 the unsigned sum of all samples of the event is compared with limit L. L is `cfg_thresh` when `cfg_coarse` = 0, and `cfg_thresh`×64 when it is 1. The event is kept when the sum is strictly greater than L with `cfg_neg` = 0, or strictly less than L with `cfg_neg` = 1. The sum of a full 64-sample event of 16383 is compared without overflow.
- R4: In mode code 0011 a sample qualifies when it is strictly greater than `cfg_thresh[13:0]` (`cfg_neg` = 0) or strictly less than it (`cfg_neg` = 1). The event is kept when it contains a run of at least `cfg_nsamp` consecutive qualifying samples.
- R5: In mode code 0011 a `cfg_nsamp` of 0 acts as 1.
- R6: In modes 0001 and 0011:
  - The keep or discard verdict appears on `out_evt_done`/`out_evt_keep` one cycle after the end-marked sample.
  - A kept event is replayed in input order, one sample per cycle, from two cycles after its end sample, or directly after the replay of an earlier kept event. Its last sample carries `out_last`.
  - A discarded event produces no `out_valid` at all.
- R7: In mode code 0010 a sample is kept if it qualifies under the rule of R4, or if it lies among the `cfg_lfwd` samples that follow a qualifying sample of the same event.
- R8: In mode code 0010 a sample is also kept when a qualifying sample of the same event arrives at most `cfg_lbk` samples later and at most `LBK_DEPTH` cycles later. Look-back never crosses an event boundary.
- R9: In mode code 0010 each sample leaves `LBK_DEPTH`+1 cycles after it entered.
  - Kept samples appear on `out_data`, with `out_last` on a kept end sample.
  - Each maximal stretch of dropped samples inside an event gives exactly one `out_skip` pulse. `out_skip_len` equals the stretch length.
  - The pulse appears in the cycle the next kept sample of that event is output, or in the cycle the event's end sample leaves.
- R10: In pass-through and zero length encoding, `out_evt_done` pulses with `out_evt_keep` = 1 in the cycle the event's end sample leaves the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_sof | input | 1 | Sample is the first of an event |
| in_eof | input | 1 | Sample is the last of an event |
| in_sample | input | SW | Unsigned converted sample |
| cfg_mode | input | 4 | Mode code |
| cfg_neg | input | 1 | 0: beyond means above, 1: beyond means below |
| cfg_coarse | input | 1 | Scale integral limit by 64 |
| cfg_thresh | input | TW | Threshold; low SW bits used per sample |
| cfg_nsamp | input | NW | Minimum qualifying run length |
| cfg_lbk | input | WW | Look-back sample count |
| cfg_lfwd | input | WW | Look-forward sample count |
| out_valid | output | 1 | Output sample valid |
| out_data | output | SW | Output sample |
| out_last | output | 1 | Output sample ends its event |
| out_skip | output | 1 | Skip marker |
| out_skip_len | output | NW | Number of samples skipped |
| out_evt_done | output | 1 | Event verdict pulse |
| out_evt_keep | output | 1 | Event was kept |

## Verification
The hardest situations to reach from the ports involve the look-back window in zero length encoding. In one, a qualifying sample arrives exactly as an earlier sample is about to leave the delay line. In another, gaps in the valid stream make the cycle bound rather than the sample count limit the reach. In a third, the window would otherwise reach into the previous event. The stimulus drives pulses with idle cycles inserted between samples, look-back counts above the line depth, and back-to-back events whose first sample qualifies. For the whole-event modes, back-to-back events are committed while an earlier 64-sample event is still replaying, so the buffer runs full and wraps.

// File: rtl/zs_filter.sv
module zs_filter #(
  parameter int SW        = 14,
  parameter int TW        = 30,
  parameter int NW        = 21,
  parameter int WW        = 16,
  parameter int DEPTH     = 64,
  parameter int LBK_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [SW-1:0] in_sample,
  input  logic [3:0]    cfg_mode,
  input  logic          cfg_neg,
  input  logic          cfg_coarse,
  input  logic [TW-1:0] cfg_thresh,
  input  logic [NW-1:0] cfg_nsamp,
  input  logic [WW-1:0] cfg_lbk,
  input  logic [WW-1:0] cfg_lfwd,
  output logic          out_valid,
  output logic [SW-1:0] out_data,
  output logic          out_last,
  output logic          out_skip,
  output logic [NW-1:0] out_skip_len,
  output logic          out_evt_done,
  output logic          out_evt_keep
);
  localparam int AW   = $clog2(DEPTH);
  localparam int SUMW = SW + NW;
  localparam int CW   = ((SUMW > TW + 6) ? SUMW : TW + 6) + 1;
  localparam int D    = LBK_DEPTH;
  localparam logic [AW:0] PSTEP = 1;
  localparam logic [NW:0] RSTEP = 1;
  localparam logic [NW-1:0] CSTEP = 1;
  localparam logic [WW-1:0] FSTEP = 1;

  wire m_int  = cfg_mode == 4'd1;
  wire m_zle  = cfg_mode == 4'd2;
  wire m_amp  = cfg_mode == 4'd3;
  wire m_fs   = m_int | m_amp;
  wire m_pass = !m_fs && !m_zle;
  wire good   = cfg_neg ? (in_sample < cfg_thresh[SW-1:0]) : (in_sample > cfg_thresh[SW-1:0]);

  // whole-event decision
  logic [SUMW-1:0] acc;
  logic [NW:0]     run;
  logic            hit;
  wire [SUMW-1:0] acc_n  = (in_sof ? '0 : acc) + SUMW'(in_sample);
  wire [CW-1:0]   sum_x  = CW'(acc_n);
  wire [CW-1:0]   lim_x  = cfg_coarse ? CW'({cfg_thresh, 6'd0}) : CW'(cfg_thresh);
  wire [NW:0]     run_n  = good ? ((in_sof ? '0 : run) + RSTEP) : '0;
  wire [NW-1:0]   ns_eff = (cfg_nsamp == '0) ? CSTEP : cfg_nsamp;
  wire hit_n   = (!in_sof && hit) || (run_n >= {1'b0, ns_eff});
  wire fs_keep = m_int ? (cfg_neg ? (sum_x < lim_x) : (sum_x > lim_x)) : hit_n;
  wire fs_in   = in_valid && m_fs;

  // event buffer
  logic [SW:0] mem [DEPTH];
  logic [AW:0] wr, rd, cm, ev0;
  wire         drain = rd != cm;
  wire [SW:0]  head  = mem[rd[AW-1:0]];

  always_ff @(posedge clk)
    if (fs_in) mem[wr[AW-1:0]] <= {in_eof, in_sample};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr <= '0; rd <= '0; cm <= '0; ev0 <= '0;
      acc <= '0; run <= '0; hit <= 1'b0;
    end else begin
      if (drain) rd <= rd + PSTEP;
      if (fs_in) begin
        acc <= acc_n;
        run <= run_n;
        hit <= hit_n;
        if (in_sof) ev0 <= wr;
        if (!in_eof) wr <= wr + PSTEP;
        else if (fs_keep) begin
          wr <= wr + PSTEP;
          cm <= wr + PSTEP;
        end else wr <= in_sof ? wr : ev0;
      end
    end

  // zero length encoding delay line
  logic [D-1:0]  dv, ds, de, dk, mark;
  logic [SW-1:0] dd [D];
  logic [WW-1:0] fwd;
  logic [NW-1:0] skc;
  wire          zle_in  = in_valid && m_zle;
  wire [WW-1:0] fwd_cur = in_sof ? '0 : fwd;
  wire          keep0   = good || (fwd_cur != '0);
  wire          lk      = dk[D-1] | mark[D-1];

  always_comb begin
    int   newer;
    logic blk;
    newer = 0;
    blk   = in_sof;
    for (int j = 0; j < D; j++) begin
      mark[j] = zle_in && good && dv[j] && !blk && ($unsigned(newer) < 32'(cfg_lbk));
      if (dv[j]) begin
        newer = newer + 1;
        blk   = blk | ds[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    dd[0] <= in_sample;
    for (int j = 1; j < D; j++) dd[j] <= dd[j-1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dv <= '0; ds <= '0; de <= '0; dk <= '0; fwd <= '0;
    end else begin
      dv <= {dv[D-2:0], zle_in};
      ds <= {ds[D-2:0], in_sof};
      de <= {de[D-2:0], in_eof};
      dk <= {dk[D-2:0] | mark[D-2:0], keep0};
      if (zle_in) fwd <= good ? cfg_lfwd : ((fwd_cur != '0) ? fwd_cur - FSTEP : '0);
    end

  // output stage
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0; out_data <= '0; out_last <= 1'b0;
      out_skip <= 1'b0; out_skip_len <= '0;
      out_evt_done <= 1'b0; out_evt_keep <= 1'b0; skc <= '0;
    end else begin
      out_valid <= 1'b0; out_last <= 1'b0; out_skip <= 1'b0;
      out_evt_done <= 1'b0; out_evt_keep <= 1'b0;
      if (drain) begin
        out_valid <= 1'b1;
        out_data  <= head[SW-1:0];
        out_last  <= head[SW];
      end
      if (fs_in && in_eof) begin
        out_evt_done <= 1'b1;
        out_evt_keep <= fs_keep;
      end
      if (in_valid && m_pass) begin
        out_valid    <= 1'b1;
        out_data     <= in_sample;
        out_last     <= in_eof;
        out_evt_done <= in_eof;
        out_evt_keep <= in_eof;
      end
      if (dv[D-1]) begin
        if (lk) begin
          out_valid <= 1'b1;
          out_data  <= dd[D-1];
          out_last  <= de[D-1];
          if (skc != '0) begin
            out_skip     <= 1'b1;
            out_skip_len <= skc;
          end
          skc <= '0;
        end else if (de[D-1]) begin
          out_skip     <= 1'b1;
          out_skip_len <= skc + CSTEP;
          skc          <= '0;
        end else skc <= skc + CSTEP;
        if (de[D-1]) begin
          out_evt_done <= 1'b1;
          out_evt_keep <= 1'b1;
        end
      end
    end

  a_r9_skip_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    out_skip |-> out_skip_len != '0);
  a_r9_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  a_r2_pass_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && m_pass) |=> (out_valid && out_data == $past(in_sample) && out_last == $past(in_eof)));
  a_r6_discard_only_whole_event: assert property (@(posedge clk) disable iff (!rst_n)
    (out_evt_done && !out_evt_keep) |-> $past(fs_in && in_eof));
  a_r6_buffer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (wr - rd) <= (AW+1)'(DEPTH));
endmodule

// File: tb/sim_zs_filter.sv
`timescale 1ns/1ps
module sim_zs_filter;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic iv = 0, isof = 0, ieof = 0;
  logic [13:0] isamp = '0;
  logic [3:0]  mode = '0;
  logic        neg = 0, coarse = 0;
  logic [29:0] thr = '0;
  logic [20:0] ns = '0;
  logic [15:0] lbk = '0, lfwd = '0;

  logic        o_valid, o_last, o_skip, o_done, o_keep;
  logic [13:0] o_data;
  logic [20:0] o_len;

  zs_filter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(iv), .in_sof(isof), .in_eof(ieof), .in_sample(isamp),
    .cfg_mode(mode), .cfg_neg(neg), .cfg_coarse(coarse), .cfg_thresh(thr), .cfg_nsamp(ns),
    .cfg_lbk(lbk), .cfg_lfwd(lfwd),
    .out_valid(o_valid), .out_data(o_data), .out_last(o_last), .out_skip(o_skip),
    .out_skip_len(o_len), .out_evt_done(o_done), .out_evt_keep(o_keep));

  typedef struct { int ev; int idx; longint cyc; bit good; bit fk; bit eof; logic [13:0] s; } zent_t;
  typedef struct { logic [13:0] s; bit last; } bent_t;
  zent_t zq[$];
  bent_t cq[$];
  bent_t stg[$];
  longint cyc = 0, accm = 0;
  int evn = 0, idx = 0, fwdm = 0, runm = 0, skm = 0;
  bit hitm = 0;

  bit e_v, e_l, e_sk, e_dn, e_kp;
  logic [13:0] e_d;
  int e_len;
  int vecs = 0, bad = 0;
  string req = "R1";

  task automatic compare();
    bit ok;
    vecs++;
    ok = (o_valid === e_v) && (o_skip === e_sk) && (o_done === e_dn);
    if (e_v) ok = ok && (o_data === e_d) && (o_last === e_l);
    if (e_sk) ok = ok && (o_len === 21'(e_len));
    if (e_dn) ok = ok && (o_keep === e_kp);
    if (!ok) begin
      bad++;
      $display("FAIL %s cyc %0d actual v=%0b d=%0d l=%0b sk=%0b len=%0d dn=%0b kp=%0b expected v=%0b d=%0d l=%0b sk=%0b len=%0d dn=%0b kp=%0b",
               req, cyc, o_valid, o_data, o_last, o_skip, o_len, o_done, o_keep,
               e_v, e_d, e_l, e_sk, e_len, e_dn, e_kp);
    end
  endtask

  task automatic model_step();
    bent_t b;
    zent_t z;
    bit g, kp;
    longint lim;
    e_v = 0; e_l = 0; e_sk = 0; e_dn = 0; e_kp = 0; e_d = '0; e_len = 0;
    if (cq.size() > 0) begin
      b = cq.pop_front();
      e_v = 1; e_d = b.s; e_l = b.last;
    end
    g = neg ? (isamp < thr[13:0]) : (isamp > thr[13:0]);
    if (iv) begin
      if (mode == 4'd1 || mode == 4'd3) begin
        if (isof) begin stg.delete(); accm = 0; runm = 0; hitm = 0; end
        b.s = isamp; b.last = ieof;
        stg.push_back(b);
        accm += longint'(isamp);
        runm = g ? runm + 1 : 0;
        if (runm >= ((ns == 0) ? 1 : int'(ns))) hitm = 1;
        if (ieof) begin
          lim = coarse ? longint'(thr) * 64 : longint'(thr);
          kp = (mode == 4'd1) ? (neg ? (accm < lim) : (accm > lim)) : hitm;
          e_dn = 1; e_kp = kp;
          if (kp) foreach (stg[k]) cq.push_back(stg[k]);
          stg.delete();
        end
      end else if (mode == 4'd2) begin
        if (isof) begin evn++; idx = 0; fwdm = 0; end
        z.ev = evn; z.idx = idx; z.cyc = cyc; z.good = g; z.fk = (fwdm > 0); z.eof = ieof; z.s = isamp;
        zq.push_back(z);
        idx++;
        if (g) fwdm = int'(lfwd); else if (fwdm > 0) fwdm--;
      end else begin
        e_v = 1; e_d = isamp; e_l = ieof; e_dn = ieof; e_kp = ieof;
      end
    end
    if (zq.size() > 0 && zq[0].cyc + D == cyc) begin
      z = zq.pop_front();
      kp = z.good || z.fk;
      foreach (zq[k])
        if (zq[k].ev == z.ev && zq[k].good && (zq[k].idx - z.idx) <= int'(lbk) && (zq[k].cyc - z.cyc) <= D)
          kp = 1;
      if (kp) begin
        e_v = 1; e_d = z.s; e_l = z.eof;
        if (skm > 0) begin e_sk = 1; e_len = skm; end
        skm = 0;
      end else if (z.eof) begin
        e_sk = 1; e_len = skm + 1; skm = 0;
      end else skm++;
      if (z.eof) begin e_dn = 1; e_kp = 1; end
    end
    cyc++;
  endtask

  task automatic step(bit v, bit s, bit e, int smp);
    iv = v; isof = s; ieof = e; isamp = 14'(smp);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0);
  endtask

  task automatic send(int vals[$], bit gaps);
    for (int k = 0; k < vals.size(); k++) begin
      step(1, k == 0, k == vals.size() - 1, vals[k]);
      if (gaps && (k % 3 == 1) && k != vals.size() - 1) step(0, 0, 0, 0);
    end
  endtask

  task automatic send_const(int n, int v);
    for (int k = 0; k < n; k++) step(1, k == 0, k == n - 1, v);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    int ev[$];
    // R1: reset state
    req = "R1";
    e_v = 0; e_l = 0; e_sk = 0; e_dn = 0; e_kp = 0; e_d = '0; e_len = 0;
    repeat (3) begin @(negedge clk); compare(); end
    rst_n = 1'b1;
    idle(3);

    // R2 pass-through, R10 event flag
    req = "R2";
    mode = 4'd0;
    ev = '{1, 2, 3, 4, 5}; send(ev, 0);
    ev = '{9, 8, 7, 6}; send(ev, 1);
    mode = 4'hB;
    ev = '{100, 200}; send(ev, 0);
    req = "R10";
    ev = '{42}; send(ev, 0);
    idle(2);

    // R3 integral
    req = "R3";
    mode = 4'd1; thr = 30'd100; neg = 0; coarse = 0;
    ev = '{30, 30, 30}; send(ev, 0);
    ev = '{50, 30, 21}; send(ev, 0);
    ev = '{50, 50}; send(ev, 0);
    idle(6);
    neg = 1;
    ev = '{10, 20}; send(ev, 1);
    ev = '{60, 60}; send(ev, 0);
    idle(6);
    neg = 0; coarse = 1; thr = 30'd2;
    ev = '{64, 63}; send(ev, 0);
    ev = '{64, 65}; send(ev, 0);
    idle(6);
    // R6 back-to-back kept events queue behind a replay
    req = "R6";
    coarse = 0; thr = 30'd10;
    ev = '{5, 6, 7, 8, 9}; send(ev, 0);
    ev = '{11, 12}; send(ev, 0);
    ev = '{1}; send(ev, 0);
    ev = '{20}; send(ev, 0);
    idle(10);
    req = "R3";
    coarse = 1; thr = 30'd16382;
    send_const(64, 16383);
    thr = 30'd16383;
    send_const(64, 16383);
    req = "R6";
    thr = 30'd1;
    send_const(64, 3);
    idle(140);

    // R4 amplitude
    req = "R4";
    mode = 4'd3; coarse = 0; thr = 30'd1000; neg = 0; ns = 21'd3;
    ev = '{1001, 1001, 5, 1001, 1001}; send(ev, 0);
    ev = '{5, 2000, 2000, 2000, 5}; send(ev, 1);
    idle(8);
    neg = 1; ns = 21'd2;
    ev = '{500, 500, 2000}; send(ev, 0);
    ev = '{500, 2000, 500}; send(ev, 0);
    idle(8);
    req = "R5";
    neg = 0; ns = 21'd0;
    ev = '{5, 1001, 5}; send(ev, 0);
    ev = '{5, 5}; send(ev, 0);
    idle(8);

    // R7 / R8 / R9 zero length encoding
    req = "R7";
    mode = 4'd2; thr = 30'd500; neg = 0; lbk = 16'd2; lfwd = 16'd3;
    ev = '{};
    for (int k = 0; k < 20; k++) ev.push_back((k == 8 || k == 9) ? 900 : 10 + k);
    send(ev, 0);
    idle(D + 3);
    req = "R9";
    send(ev, 1);
    ev = '{1, 2, 3, 4, 5, 6}; send(ev, 0);
    idle(D + 3);
    req = "R8";
    lbk = 16'd20; lfwd = 16'd0;
    ev = '{};
    for (int k = 0; k < 16; k++) ev.push_back(k == 12 ? 700 : 3);
    send(ev, 0);
    send(ev, 1);
    ev = '{4, 4, 4}; send(ev, 0);
    ev = '{800, 4, 4}; send(ev, 0);
    idle(D + 3);
    neg = 1; lbk = 16'd0; lfwd = 16'd1;
    ev = '{900, 100, 900, 900, 100, 900, 900, 900}; send(ev, 0);
    idle(D + 3);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule